// File: doc/BRIEF.md
# Crossbar Error Capture Unit

This block gathers error pulses raised by the queues around an on-chip crossbar. Each pulse arrives on a queue's own input, tagged with an error kind and a channel. The block keeps one sticky status register per queue, and one first-error register that holds the earliest error not yet acknowledged. Each queue class has a fixed set of error kinds it can produce. Pulses of any other kind, or on a channel the queue does not use, are dropped.

Software reaches every register through one flat read/write port. A write to a per-queue register replaces its contents, which is how bits are cleared. A write that leaves supported bits set also counts as an error event, so software can inject errors for test. The first-error register cannot be loaded by a write. A write to its address only asks for it to be cleared, and that request is honoured only after the error bit it names has been cleared in its queue register. A single interrupt level goes to two processor interfaces and stays high while any error is recorded.

With the defaults there are six queues, with source numbers in this order:
- 0 and 1: processor output queues.
- 2 and 3: memory output queues.
- 4: processor input queue.
- 5: local input queue.

Top module: `xbe_capture_top`

## Requirements
- R1: While reset is low, and right after it is released, every queue register reads 0, the first-error register reads 0 and both interrupt outputs are low.
- R2: Error kind codes are: 0 overflow, 1 underflow, 2 tail timeout, 3 invalid crossbar select, 4 deadlock timeout. A supported pulse sets bit kind*2+channel of its queue register. The bit can be read after the next rising edge and stays set until software clears it.
- R3: Each queue class accepts only these kinds; a pulse of any other kind changes no register and raises no interrupt:

  | Queues | Class | Accepted kinds | Supported-bit mask |
  |---|---|---|---|
  | 0 and 1 | processor output | 0, 1, 2, 3 | 0x0FF |
  | 2 and 3 | memory output | 0, 1, 2 | 0x03F |
  | 4 | processor input | 0, 4 | 0x303 |
- R4: Queue 5 (local input) accepts kinds 0 and 4 on channel 0 only. Pulses on channel 1 are ignored.
- R5: A write to address q (0 to 5) loads the queue register with reg_wdata ANDed with that queue's supported-bit mask. If a pulse arrives in the same cycle, its bit is still set: set wins over clear.
- R6: Address 6 reads the first-error register as: bits 3:0 kind, bits 7:4 channel, bits 11:8 source queue, bit 12 valid, bits 15:13 zero. An error is captured into it only when valid is clear at that clock edge.
- R7: When several queues report in the same cycle and valid is clear, the lowest-numbered source is captured.
- R8: While valid is set, later errors do not alter the first-error register.
- R9: A queue-register write that leaves any supported bit set is captured as an error. Its source is the written address, and its kind and channel are those of the lowest set bit.
- R10: A write to address 6 clears the first-error register only if the queue bit it names is already 0. Otherwise the register is left unchanged.
- R11: irq_pi0 and irq_pi1 are always equal. They are high when first-error valid is set or any queue register bit is set.
- R12: Reads from addresses above 6 return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_vld | input | 6 | Error pulse, one bit per queue |
| ev_kind | input | 18 | Error kind per queue, 3 bits each, queue q at bits 3q+2:3q |
| ev_chan | input | 6 | Channel per queue, 1 bit each |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_pi0 | output | 1 | Interrupt to processor interface 0 |
| irq_pi1 | output | 1 | Interrupt to processor interface 1 |

## Verification
A wrong queue bit shows up one edge after the pulse. It reads back wrong at that queue's address, and it may also move the interrupt or the first-error capture. A capture that goes wrong, such as the wrong priority winner, an overwrite while valid, or a kind that should have been dropped, shows in the address 6 read on the following cycle. A broken clear-ordering check shows as the first-error register emptying, or holding, on the cycle after the write to address 6. It also shows as the interrupt falling early or staying high after every register has been cleared.

// File: rtl/xbe_pkg.sv
// Shared kinds, queue classes and supported-bit mask computation for the
// crossbar error capture unit. Assumes at most 16 queues and 16 channels.
package xbe_pkg;
    localparam int KIND_N = 5;
    localparam int KW     = 3;

    typedef enum logic [KW-1:0] {
        K_OVF  = 3'd0,
        K_UNF  = 3'd1,
        K_TAIL = 3'd2,
        K_XSEL = 3'd3,
        K_DEAD = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        QC_POUT,
        QC_MOUT,
        QC_PIN,
        QC_LIN
    } qclass_e;

    // Kinds a queue class can physically produce.
    function automatic logic [KIND_N-1:0] kinds_of(qclass_e c);
        case (c)
            QC_POUT: kinds_of = 5'b01111;
            QC_MOUT: kinds_of = 5'b00111;
            default: kinds_of = 5'b10001;
        endcase
    endfunction

    // Supported bits of a queue register: bit kind*nch+chan.
    function automatic logic [31:0] reg_mask(qclass_e c, int nch);
        logic [KIND_N-1:0] ks;
        reg_mask = '0;
        ks = kinds_of(c);
        for (int k = 0; k < KIND_N; k++)
            for (int ch = 0; ch < nch; ch++)
                if (ks[k] && !(c == QC_LIN && ch != 0))
                    reg_mask[k*nch+ch] = 1'b1;
    endfunction
endpackage

// File: rtl/xbe_qreg.sv
// One queue's sticky error register. It filters pulses against MASK, applies
// software writes (set wins over clear) and offers one capture candidate per
// cycle. Assumes ev_kind and ev_chan are only meaningful while ev_vld is high.
module xbe_qreg #(
    parameter int NUM_CH = 2,
    parameter int CHW    = 1,
    parameter int REGW   = 10,
    parameter logic [REGW-1:0] MASK = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ev_vld,
    input  logic [xbe_pkg::KW-1:0] ev_kind,
    input  logic [CHW-1:0]         ev_chan,
    input  logic                   wr_en,
    input  logic [REGW-1:0]        wr_data,
    output logic [REGW-1:0]        q_bits,
    output logic                   cand_vld,
    output logic [xbe_pkg::KW-1:0] cand_kind,
    output logic [CHW-1:0]         cand_chan
);
    import xbe_pkg::*;

    logic [REGW-1:0] set_vec;
    logic [REGW-1:0] wr_set;
    logic            ev_ok;

    assign wr_set = wr_data & MASK;

    // Decode an incoming pulse into a bit, dropping unsupported kinds/channels.
    always_comb begin
        set_vec = '0;
        ev_ok   = 1'b0;
        for (int k = 0; k < KIND_N; k++)
            for (int c = 0; c < NUM_CH; c++)
                if (ev_vld && int'(ev_kind) == k && int'(ev_chan) == c && MASK[k*NUM_CH+c]) begin
                    set_vec[k*NUM_CH+c] = 1'b1;
                    ev_ok = 1'b1;
                end
    end

    // Offer a capture candidate: a hardware pulse first, else the lowest bit a write sets.
    always_comb begin
        cand_vld  = 1'b0;
        cand_kind = '0;
        cand_chan = '0;
        if (ev_ok) begin
            cand_vld  = 1'b1;
            cand_kind = ev_kind;
            cand_chan = ev_chan;
        end else if (wr_en && |wr_set) begin
            cand_vld = 1'b1;
            for (int k = KIND_N-1; k >= 0; k--)
                for (int c = NUM_CH-1; c >= 0; c--)
                    if (wr_set[k*NUM_CH+c]) begin
                        cand_kind = KW'(k);
                        cand_chan = CHW'(c);
                    end
        end
    end

    // Sticky storage: a write replaces the contents, a pulse always sets.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_bits <= '0;
        else if (wr_en)
            q_bits <= wr_set | set_vec;
        else
            q_bits <= q_bits | set_vec;
    end
endmodule

// File: rtl/xbe_first.sv
// First-error register. It captures the lowest-numbered candidate while
// empty and holds while valid. A clear request is honoured only once the
// recorded queue bit has gone to zero (rec_bit_set low).
module xbe_first #(
    parameter int NUM_Q = 6,
    parameter int CHW   = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_Q-1:0]             cand_vld,
    input  logic [NUM_Q*xbe_pkg::KW-1:0] cand_kind,
    input  logic [NUM_Q*CHW-1:0]         cand_chan,
    input  logic                         clr_req,
    input  logic                         rec_bit_set,
    output logic                         fe_valid,
    output logic [3:0]                   fe_src,
    output logic [3:0]                   fe_chan,
    output logic [3:0]                   fe_type
);
    import xbe_pkg::*;

    logic [3:0]    pick_src;
    logic [KW-1:0] pick_kind;
    logic [CHW-1:0] pick_chan;

    // Priority pick: the lowest source index wins.
    always_comb begin
        pick_src  = '0;
        pick_kind = '0;
        pick_chan = '0;
        for (int i = NUM_Q-1; i >= 0; i--)
            if (cand_vld[i]) begin
                pick_src  = 4'(i);
                pick_kind = cand_kind[i*KW +: KW];
                pick_chan = cand_chan[i*CHW +: CHW];
            end
    end

    // Capture while empty; clear only when the named queue bit is gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fe_valid <= 1'b0;
            fe_src   <= '0;
            fe_chan  <= '0;
            fe_type  <= '0;
        end else if (fe_valid) begin
            if (clr_req && !rec_bit_set) begin
                fe_valid <= 1'b0;
                fe_src   <= '0;
                fe_chan  <= '0;
                fe_type  <= '0;
            end
        end else if (|cand_vld) begin
            fe_valid <= 1'b1;
            fe_src   <= pick_src;
            fe_chan  <= 4'(pick_chan);
            fe_type  <= 4'(pick_kind);
        end
    end
endmodule

// File: rtl/xbe_capture_top.sv
// Crossbar error capture unit top. It holds one sticky register per queue
// and the first-error register, and drives a shared interrupt to two
// processor interfaces. Queue classes are laid out by source number:
// processor outputs, then memory outputs, then processor inputs, then
// local inputs. Assumes NUM_Q <= 15 so that the first-error address fits
// in 4 bits.
module xbe_capture_top #(
    parameter int NUM_POUT = 2,
    parameter int NUM_MOUT = 2,
    parameter int NUM_PIN  = 1,
    parameter int NUM_LIN  = 1,
    parameter int NUM_CH   = 2,
    localparam int NUM_Q   = NUM_POUT + NUM_MOUT + NUM_PIN + NUM_LIN,
    localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int REGW    = xbe_pkg::KIND_N * NUM_CH,
    localparam int AW      = 4,
    localparam int RDW     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_Q-1:0]             ev_vld,
    input  logic [NUM_Q*xbe_pkg::KW-1:0] ev_kind,
    input  logic [NUM_Q*CHW-1:0]         ev_chan,
    input  logic                         reg_we,
    input  logic [AW-1:0]                reg_addr,
    input  logic [REGW-1:0]              reg_wdata,
    output logic [RDW-1:0]               reg_rdata,
    output logic                         irq_pi0,
    output logic                         irq_pi1
);
    import xbe_pkg::*;

    function automatic qclass_e class_of(int i);
        if (i < NUM_POUT)                          class_of = QC_POUT;
        else if (i < NUM_POUT + NUM_MOUT)          class_of = QC_MOUT;
        else if (i < NUM_POUT + NUM_MOUT + NUM_PIN) class_of = QC_PIN;
        else                                       class_of = QC_LIN;
    endfunction

    logic [REGW-1:0]     q_bits [NUM_Q];
    logic [NUM_Q-1:0]    cand_vld;
    logic [NUM_Q*KW-1:0] cand_kind;
    logic [NUM_Q*CHW-1:0] cand_chan;
    logic                fe_valid;
    logic [3:0]          fe_src, fe_chan, fe_type;
    logic                fe_clr;
    logic                rec_bit;
    logic                any_err;

    assign fe_clr = reg_we && (reg_addr == AW'(NUM_Q));

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        localparam logic [REGW-1:0] QMASK = REGW'(reg_mask(class_of(i), NUM_CH));
        xbe_qreg #(.NUM_CH(NUM_CH), .CHW(CHW), .REGW(REGW), .MASK(QMASK)) u_qreg (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_vld    (ev_vld[i]),
            .ev_kind   (ev_kind[i*KW +: KW]),
            .ev_chan   (ev_chan[i*CHW +: CHW]),
            .wr_en     (reg_we && (reg_addr == AW'(i))),
            .wr_data   (reg_wdata),
            .q_bits    (q_bits[i]),
            .cand_vld  (cand_vld[i]),
            .cand_kind (cand_kind[i*KW +: KW]),
            .cand_chan (cand_chan[i*CHW +: CHW])
        );
    end

    xbe_first #(.NUM_Q(NUM_Q), .CHW(CHW)) u_first (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_vld    (cand_vld),
        .cand_kind   (cand_kind),
        .cand_chan   (cand_chan),
        .clr_req     (fe_clr),
        .rec_bit_set (rec_bit),
        .fe_valid    (fe_valid),
        .fe_src      (fe_src),
        .fe_chan     (fe_chan),
        .fe_type     (fe_type)
    );

    // Look up the queue bit named by the first-error register.
    always_comb begin
        rec_bit = 1'b0;
        for (int i = 0; i < NUM_Q; i++)
            for (int k = 0; k < KIND_N; k++)
                for (int c = 0; c < NUM_CH; c++)
                    if (fe_src == 4'(i) && fe_type == 4'(k) && fe_chan == 4'(c))
                        rec_bit = rec_bit | q_bits[i][k*NUM_CH+c];
    end

    // Reduce all queue registers to a single pending flag.
    always_comb begin
        any_err = 1'b0;
        for (int i = 0; i < NUM_Q; i++)
            any_err = any_err | (|q_bits[i]);
    end

    // Read mux for the flat register space; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (reg_addr == AW'(i))
                reg_rdata = RDW'(q_bits[i]);
        if (reg_addr == AW'(NUM_Q))
            reg_rdata = {3'b000, fe_valid, fe_src, fe_chan, fe_type};
    end

    assign irq_pi0 = fe_valid | any_err;
    assign irq_pi1 = fe_valid | any_err;
endmodule

// File: rtl/xbe_capture_sva.sv
// Property checker for xbe_capture_top, attached by bind below. It observes
// the interrupt pair and the first-error register through capture and
// clear, and assumes reset is held low over at least one rising edge.
module xbe_capture_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_pi0,
    input logic       irq_pi1,
    input logic       fe_valid,
    input logic [3:0] fe_src,
    input logic [3:0] fe_chan,
    input logic [3:0] fe_type,
    input logic       fe_clr,
    input logic       rec_bit,
    input logic       cand_any
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_pi0 && !fe_valid));

    a_r11_irq_pair: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pi0 == irq_pi1);

    a_r11_irq_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fe_valid |-> irq_pi0);

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!fe_valid && cand_any) |=> fe_valid);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && !fe_clr) |=> (fe_valid && $stable(fe_src) && $stable(fe_chan) && $stable(fe_type)));

    a_r10_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_clr && rec_bit) |=> fe_valid);

    a_r10_clear_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && fe_clr && !rec_bit) |=> !fe_valid);
endmodule

bind xbe_capture_top xbe_capture_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pi0  (irq_pi0),
    .irq_pi1  (irq_pi1),
    .fe_valid (fe_valid),
    .fe_src   (fe_src),
    .fe_chan  (fe_chan),
    .fe_type  (fe_type),
    .fe_clr   (fe_clr),
    .rec_bit  (rec_bit),
    .cand_any (|cand_vld)
);

// File: tb/xbe_capture_top_bench.sv
// Directed bench for xbe_capture_top: one task per scenario, each checking its own results.
module xbe_capture_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ev_vld = '0;
    logic [17:0] ev_kind = '0;
    logic [5:0]  ev_chan = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [9:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_pi0, irq_pi1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    xbe_capture_top u_xbe_capture_top (
        .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_kind(ev_kind), .ev_chan(ev_chan),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_pi0(irq_pi0), .irq_pi1(irq_pi1)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input string req, input int a, input logic [15:0] exp);
        reg_addr = 4'(a);
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic chk_irq(input string req, input logic exp);
        chk(req, {14'd0, irq_pi1, irq_pi0}, {14'd0, exp, exp});
    endtask

    task automatic arm(input int q, input int k, input int c);
        ev_vld[q] = 1'b1;
        ev_kind[q*3 +: 3] = 3'(k);
        ev_chan[q] = 1'(c);
    endtask

    task automatic tick();
        @(negedge clk);
        ev_vld = '0;
        reg_we = 1'b0;
    endtask

    task automatic pulse(input int q, input int k, input int c);
        @(negedge clk);
        arm(q, k, c);
        tick();
    endtask

    task automatic wr(input int a, input logic [9:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 4'(a);
        reg_wdata = d;
        tick();
    endtask

    task automatic t_reset();
        for (int a = 0; a < 7; a++) rd("R1", a, 16'h0);
        chk_irq("R1", 1'b0);
    endtask

    task automatic t_capture_and_order();
        pulse(0, 1, 1);
        rd("R2", 0, 16'h008);
        rd("R6", 6, 16'h1011);
        chk_irq("R11", 1'b1);
        pulse(2, 0, 0);
        rd("R2", 2, 16'h001);
        rd("R8", 6, 16'h1011);
        wr(6, 10'h0);
        rd("R10", 6, 16'h1011);
        wr(0, 10'h0);
        rd("R5", 0, 16'h000);
        chk_irq("R11", 1'b1);
        wr(6, 10'h0);
        rd("R10", 6, 16'h0000);
        chk_irq("R11", 1'b1);
        wr(2, 10'h0);
        chk_irq("R11", 1'b0);
    endtask

    task automatic t_unsupported();
        pulse(2, 3, 0);
        rd("R3", 2, 16'h0);
        rd("R3", 6, 16'h0);
        pulse(4, 1, 0);
        rd("R3", 4, 16'h0);
        chk_irq("R3", 1'b0);
        pulse(5, 0, 1);
        rd("R4", 5, 16'h0);
        chk_irq("R4", 1'b0);
        pulse(5, 4, 0);
        rd("R4", 5, 16'h100);
        rd("R4", 6, 16'h1504);
        wr(5, 10'h0);
        wr(6, 10'h0);
        chk_irq("R4", 1'b0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        arm(3, 2, 0);
        arm(1, 3, 1);
        tick();
        rd("R7", 6, 16'h1113);
        rd("R2", 3, 16'h010);
        rd("R2", 1, 16'h080);
        wr(1, 10'h0);
        wr(3, 10'h0);
        wr(6, 10'h0);
        rd("R7", 6, 16'h0);
        chk_irq("R11", 1'b0);
    endtask

    task automatic t_sw_write();
        wr(4, 10'h3FF);
        rd("R5", 4, 16'h303);
        rd("R9", 6, 16'h1400);
        chk_irq("R11", 1'b1);
        wr(0, 10'h3FF);
        rd("R5", 0, 16'h0FF);
        rd("R8", 6, 16'h1400);
        wr(0, 10'h0);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 4'd4;
        reg_wdata = 10'h0;
        arm(4, 4, 1);
        tick();
        rd("R5", 4, 16'h200);
        wr(6, 10'h0);
        rd("R10", 6, 16'h0);
        chk_irq("R11", 1'b1);
        wr(4, 10'h0);
        chk_irq("R11", 1'b0);
    endtask

    task automatic t_bad_addr();
        wr(9, 10'h3FF);
        rd("R12", 9, 16'h0);
        rd("R12", 6, 16'h0);
        chk_irq("R12", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd("R1", 6, 16'h0);
        chk_irq("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_and_order();
        t_unsupported();
        t_priority();
        t_sw_write();
        t_bad_addr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule